// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the program order of micro-operations in a machine whose execution units finish work in any order. Up to three micro-operations enter at the tail in each cycle, and each one receives a slot tag. Execution units later use that tag to report a result, a fault flag and, for branches, a misprediction flag together with the resolved target. The block then commits finished work from the head, at most three per cycle, strictly oldest first. Committed results go into an internal architectural register file, and stores receive their memory release at this point.

Recovery happens only at the commit point. A mispredicted branch commits together with everything older than it. In the same cycle the block drives a redirect with the resolved target and throws away every younger slot. A faulting micro-operation is reported only once it becomes the oldest unfinished work. It writes nothing, and it is discarded together with everything younger.

Top module: `rob_inorder`

## Requirements
- R1: After reset the buffer is empty, `alloc_ready` is 1, no lane retires, no redirect or fault is reported and every architectural register reads 0.
- R2: An allocation accepts 1 to 3 micro-ops on lanes filled from lane 0 upward. Lane l receives tag (tail + l) mod 40, and the tail advances by the number of lanes accepted.
- R3: `alloc_ready` is 0 whenever fewer than 3 of the 40 slots are free. A request made while it is 0 takes no slot.
- R4: A writeback may arrive in any order and marks its slot finished with the given result, fault flag and mispredict flag.
- R5: Up to 3 finished micro-ops retire per cycle in tag order from the head. Retirement stops at the first slot that is unfinished, faulting or past the oldest mispredicted branch. Retire lane 0 is always the oldest.
- R6: The architectural register file changes only at the clock edge that ends the cycle in which an entry with a register destination shows on a retire lane.
- R7: `ret_store` is raised for a store only in the cycle it retires, never while older work is still pending.
- R8: When a mispredicted branch reaches retirement it retires with all older lanes, `redirect_valid` is 1 and `redirect_pc` equals the result it was written back with. All younger entries are discarded and never retire, and the next allocation receives the tag just after the branch.
- R9: A faulting entry raises `fault_valid` with its allocation address only when every older entry has retired. The faulting entry and all younger ones write nothing, and the next allocation reuses the faulting tag.
- R10: Head and tail wrap from tag 39 to tag 0 without losing order.
- R11: During a redirect or fault cycle `alloc_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 3 | Per-lane allocation request, prefix from lane 0 |
| alloc_wr_en | input | 3 | Lane writes a destination register |
| alloc_is_br | input | 3 | Lane is a branch |
| alloc_is_st | input | 3 | Lane is a store |
| alloc_dst | input | 12 | Destination register per lane, 4 bits each |
| alloc_pc | input | 96 | Instruction address per lane, 32 bits each |
| alloc_ready | output | 1 | At least 3 slots free and no flush this cycle |
| alloc_tag | output | 18 | Tag for each lane, 6 bits each |
| wb_valid | input | 3 | Writeback lane valid |
| wb_fault | input | 3 | Writeback reports a fault |
| wb_mispred | input | 3 | Writeback reports a mispredicted branch |
| wb_tag | input | 18 | Slot tag per writeback lane |
| wb_val | input | 96 | Result per lane; resolved target for branches |
| ret_valid | output | 3 | Lane retires this cycle |
| ret_wr_en | output | 3 | Retiring lane writes a register |
| ret_store | output | 3 | Retiring lane releases a store |
| ret_dst | output | 12 | Destination of each retiring lane |
| ret_val | output | 96 | Result of each retiring lane |
| redirect_valid | output | 1 | Mispredicted branch retires this cycle |
| redirect_pc | output | 32 | Fetch restart address |
| fault_valid | output | 1 | Faulting entry reached the commit point |
| fault_pc | output | 32 | Address of the faulting entry |
| arf_raddr | input | 4 | Architectural register read address |
| arf_rdata | output | 32 | Architectural register read data |

## Verification
The hardest case to reach is a full buffer whose tags have wrapped past slot 39. To get there, the stimulus first commits three micro-ops, then fills 39 slots without any writeback so that the last group straddles the wrap. It then tries an allocation that must be refused, and drains the buffer at full width. Flush cases are built by completing the younger work before the older work. This makes younger finished entries wait behind an unfinished head, so that only the discard can keep them from retiring once the mispredicted branch or the fault reaches the head.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int ROB_DEPTH = 40;
    localparam int LANES     = 3;
    localparam int DATA_W    = 32;
    localparam int PC_W      = 32;
    localparam int AREG_N    = 16;

    localparam int TAG_W  = $clog2(ROB_DEPTH);
    localparam int CNT_W  = $clog2(ROB_DEPTH + 1);
    localparam int AREG_W = $clog2(AREG_N);
    localparam int LN_W   = $clog2(LANES + 1);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [LN_W-1:0]   lane_cnt_t;
    typedef logic [AREG_W-1:0] areg_t;

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              fault;
        logic              is_br;
        logic              mispred;
        logic              is_st;
        logic              wr_en;
        areg_t             dst;
        logic [DATA_W-1:0] val;
        logic [PC_W-1:0]   pc;
    } rob_ent_t;

    // Advance a slot tag by a small step, wrapping at the buffer depth.
    function automatic tag_t tag_adv(tag_t base, lane_cnt_t step);
        logic [TAG_W:0] sum;
        sum = {1'b0, base} + {{(TAG_W + 1 - LN_W){1'b0}}, step};
        if (sum >= (TAG_W + 1)'(ROB_DEPTH)) begin
            sum = sum - (TAG_W + 1)'(ROB_DEPTH);
        end
        return sum[TAG_W-1:0];
    endfunction

endpackage

// File: rtl/rob_alloc_ctrl.sv
module rob_alloc_ctrl
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tag_t             tail,
    input  cnt_t             count,
    input  logic             flush,
    input  logic [LANES-1:0] req,
    output logic             ready,
    output logic [LANES-1:0] fire,
    output tag_t             lane_tag [LANES],
    output lane_cnt_t        n_fire
);

    cnt_t free_slots;

    assign free_slots = cnt_t'(ROB_DEPTH) - count;
    assign ready      = (free_slots >= cnt_t'(LANES)) && !flush;
    assign fire       = ready ? req : '0;

    for (genvar l = 0; l < LANES; l++) begin : g_tag
        assign lane_tag[l] = tag_adv(tail, lane_cnt_t'(l));
    end

    always_comb begin
        n_fire = '0;
        for (int l = 0; l < LANES; l++) begin
            n_fire = n_fire + lane_cnt_t'(fire[l]);
        end
    end

    // Lanes must be filled from lane 0 upward (R2).
    for (genvar l = 1; l < LANES; l++) begin : g_prefix
        p_alloc_prefix_r2 : assert property (@(posedge clk) disable iff (rst)
            req[l] |-> req[l-1]);
    end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rob_ent_t         win [LANES],
    input  cnt_t             count,
    output logic [LANES-1:0] go,
    output lane_cnt_t        n_go,
    output logic             br_flush,
    output logic             fault_hit,
    output logic [PC_W-1:0]  redirect_pc,
    output logic [PC_W-1:0]  fault_pc
);

    always_comb begin
        logic stop;
        stop        = 1'b0;
        go          = '0;
        n_go        = '0;
        br_flush    = 1'b0;
        fault_hit   = 1'b0;
        redirect_pc = '0;
        fault_pc    = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!stop) begin
                if ((cnt_t'(l) < count) && win[l].valid && win[l].done) begin
                    if (win[l].fault) begin
                        fault_hit = 1'b1;
                        fault_pc  = win[l].pc;
                        stop      = 1'b1;
                    end else begin
                        go[l] = 1'b1;
                        n_go  = n_go + lane_cnt_t'(1);
                        if (win[l].is_br && win[l].mispred) begin
                            br_flush    = 1'b1;
                            redirect_pc = win[l].val[PC_W-1:0];
                            stop        = 1'b1;
                        end
                    end
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

    for (genvar l = 1; l < LANES; l++) begin : g_order
        p_retire_order_r5 : assert property (@(posedge clk) disable iff (rst)
            go[l] |-> go[l-1]);
    end

    p_single_cause_r9 : assert property (@(posedge clk) disable iff (rst)
        !(br_flush && fault_hit));

endmodule

// File: rtl/rob_arch_regs.sv
module rob_arch_regs
    import rob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  we,
    input  areg_t             waddr [LANES],
    input  logic [DATA_W-1:0] wdata [LANES],
    input  areg_t             raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [AREG_N];

    // Later lanes are younger, so their write lands last and wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < AREG_N; r++) begin
                regs[r] <= '0;
            end
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (we[l]) begin
                    regs[waddr[l]] <= wdata[l];
                end
            end
        end
    end

    assign rdata = regs[raddr];

    p_arf_hold_r6 : assert property (@(posedge clk) disable iff (rst)
        (we == '0) ##1 $stable(raddr) |-> $stable(rdata));

endmodule

// File: rtl/rob_inorder.sv
module rob_inorder
    import rob_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        alloc_valid,
    input  logic [LANES-1:0]        alloc_wr_en,
    input  logic [LANES-1:0]        alloc_is_br,
    input  logic [LANES-1:0]        alloc_is_st,
    input  logic [LANES*AREG_W-1:0] alloc_dst,
    input  logic [LANES*PC_W-1:0]   alloc_pc,
    output logic                    alloc_ready,
    output logic [LANES*TAG_W-1:0]  alloc_tag,
    input  logic [LANES-1:0]        wb_valid,
    input  logic [LANES-1:0]        wb_fault,
    input  logic [LANES-1:0]        wb_mispred,
    input  logic [LANES*TAG_W-1:0]  wb_tag,
    input  logic [LANES*DATA_W-1:0] wb_val,
    output logic [LANES-1:0]        ret_valid,
    output logic [LANES-1:0]        ret_wr_en,
    output logic [LANES-1:0]        ret_store,
    output logic [LANES*AREG_W-1:0] ret_dst,
    output logic [LANES*DATA_W-1:0] ret_val,
    output logic                    redirect_valid,
    output logic [PC_W-1:0]         redirect_pc,
    output logic                    fault_valid,
    output logic [PC_W-1:0]         fault_pc,
    input  logic [AREG_W-1:0]       arf_raddr,
    output logic [DATA_W-1:0]       arf_rdata
);

    rob_ent_t ent [ROB_DEPTH];
    tag_t     head_q, tail_q;
    cnt_t     count_q;

    tag_t              ret_idx   [LANES];
    rob_ent_t          win       [LANES];
    tag_t              lane_tag  [LANES];
    rob_ent_t          new_ent   [LANES];
    tag_t              wb_tag_a  [LANES];
    logic [DATA_W-1:0] wb_val_a  [LANES];
    areg_t             ret_dst_a [LANES];
    logic [DATA_W-1:0] ret_val_a [LANES];

    logic [LANES-1:0] fire, go;
    lane_cnt_t        n_fire, n_go;
    logic             br_flush, fault_hit, flush;
    tag_t             new_head;

    assign flush    = br_flush || fault_hit;
    assign new_head = tag_adv(head_q, n_go);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign ret_idx[l]  = tag_adv(head_q, lane_cnt_t'(l));
        assign win[l]      = ent[ret_idx[l]];
        assign wb_tag_a[l] = wb_tag[l*TAG_W +: TAG_W];
        assign wb_val_a[l] = wb_val[l*DATA_W +: DATA_W];

        assign new_ent[l] = '{valid:   1'b1,
                              done:    1'b0,
                              fault:   1'b0,
                              is_br:   alloc_is_br[l],
                              mispred: 1'b0,
                              is_st:   alloc_is_st[l],
                              wr_en:   alloc_wr_en[l],
                              dst:     alloc_dst[l*AREG_W +: AREG_W],
                              val:     '0,
                              pc:      alloc_pc[l*PC_W +: PC_W]};

        assign alloc_tag[l*TAG_W +: TAG_W] = lane_tag[l];

        assign ret_wr_en[l]    = go[l] && win[l].wr_en;
        assign ret_store[l]    = go[l] && win[l].is_st;
        assign ret_dst_a[l]    = win[l].dst;
        assign ret_val_a[l]    = win[l].val;
        assign ret_dst[l*AREG_W +: AREG_W] = ret_dst_a[l];
        assign ret_val[l*DATA_W +: DATA_W] = ret_val_a[l];
    end

    assign ret_valid      = go;
    assign redirect_valid = br_flush;
    assign fault_valid    = fault_hit;

    rob_alloc_ctrl u_alloc (
        .clk      (clk),
        .rst      (rst),
        .tail     (tail_q),
        .count    (count_q),
        .flush    (flush),
        .req      (alloc_valid),
        .ready    (alloc_ready),
        .fire     (fire),
        .lane_tag (lane_tag),
        .n_fire   (n_fire)
    );

    rob_retire_sel u_retire (
        .clk         (clk),
        .rst         (rst),
        .win         (win),
        .count       (count_q),
        .go          (go),
        .n_go        (n_go),
        .br_flush    (br_flush),
        .fault_hit   (fault_hit),
        .redirect_pc (redirect_pc),
        .fault_pc    (fault_pc)
    );

    rob_arch_regs u_arf (
        .clk   (clk),
        .rst   (rst),
        .we    (ret_wr_en),
        .waddr (ret_dst_a),
        .wdata (ret_val_a),
        .raddr (arf_raddr),
        .rdata (arf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            for (int i = 0; i < ROB_DEPTH; i++) begin
                ent[i] <= '0;
            end
        end else begin
            // Completion: out of order, only into live slots.
            for (int l = 0; l < LANES; l++) begin
                if (wb_valid[l] && (wb_tag_a[l] < tag_t'(ROB_DEPTH))
                        && ent[wb_tag_a[l]].valid) begin
                    ent[wb_tag_a[l]].done    <= 1'b1;
                    ent[wb_tag_a[l]].fault   <= wb_fault[l];
                    ent[wb_tag_a[l]].mispred <= wb_mispred[l];
                    ent[wb_tag_a[l]].val     <= wb_val_a[l];
                end
            end
            // Retirement frees the oldest slots.
            for (int l = 0; l < LANES; l++) begin
                if (go[l]) begin
                    ent[ret_idx[l]].valid <= 1'b0;
                end
            end
            head_q <= new_head;
            if (flush) begin
                // Everything not retiring this cycle is younger: drop it.
                for (int i = 0; i < ROB_DEPTH; i++) begin
                    ent[i].valid <= 1'b0;
                end
                tail_q  <= new_head;
                count_q <= '0;
            end else begin
                for (int l = 0; l < LANES; l++) begin
                    if (fire[l]) begin
                        ent[lane_tag[l]] <= new_ent[l];
                    end
                end
                tail_q  <= tag_adv(tail_q, n_fire);
                count_q <= count_q + cnt_t'(n_fire) - cnt_t'(n_go);
            end
        end
    end

    p_count_track_r2 : assert property (@(posedge clk) disable iff (rst)
        !flush |=> count_q == cnt_t'($past(count_q) + cnt_t'($past(n_fire))
                                      - cnt_t'($past(n_go))));

    p_no_overflow_r3 : assert property (@(posedge clk) disable iff (rst)
        count_q <= cnt_t'(ROB_DEPTH));

    p_ptr_range_r10 : assert property (@(posedge clk) disable iff (rst)
        (head_q < tag_t'(ROB_DEPTH)) && (tail_q < tag_t'(ROB_DEPTH)));

    p_flush_empty_r8 : assert property (@(posedge clk) disable iff (rst)
        flush |=> (ret_valid == '0) && (head_q == tail_q));

    p_store_release_r7 : assert property (@(posedge clk) disable iff (rst)
        (ret_store & ~ret_valid) == '0);

    p_flush_blocks_alloc_r11 : assert property (@(posedge clk) disable iff (rst)
        flush |-> !alloc_ready);

endmodule

// File: tb/tb_rob_inorder.sv
module tb_rob_inorder;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  alloc_valid = '0, alloc_wr_en = '0, alloc_is_br = '0, alloc_is_st = '0;
    logic [11:0] alloc_dst = '0;
    logic [95:0] alloc_pc = '0;
    logic        alloc_ready;
    logic [17:0] alloc_tag;
    logic [2:0]  wb_valid = '0, wb_fault = '0, wb_mispred = '0;
    logic [17:0] wb_tag = '0;
    logic [95:0] wb_val = '0;
    logic [2:0]  ret_valid, ret_wr_en, ret_store;
    logic [11:0] ret_dst;
    logic [95:0] ret_val;
    logic        redirect_valid, fault_valid;
    logic [31:0] redirect_pc, fault_pc;
    logic [3:0]  arf_raddr = '0;
    logic [31:0] arf_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rob_inorder dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_wr_en(alloc_wr_en),
        .alloc_is_br(alloc_is_br), .alloc_is_st(alloc_is_st),
        .alloc_dst(alloc_dst), .alloc_pc(alloc_pc),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .wb_valid(wb_valid), .wb_fault(wb_fault), .wb_mispred(wb_mispred),
        .wb_tag(wb_tag), .wb_val(wb_val),
        .ret_valid(ret_valid), .ret_wr_en(ret_wr_en), .ret_store(ret_store),
        .ret_dst(ret_dst), .ret_val(ret_val),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .fault_valid(fault_valid), .fault_pc(fault_pc),
        .arf_raddr(arf_raddr), .arf_rdata(arf_rdata)
    );

    typedef struct {
        logic        wr;
        logic [3:0]  dst;
        logic [31:0] val;
        logic        st;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] val_of [DEPTH];
    logic [31:0] pc_of  [DEPTH];
    int          checks = 0;
    int          errors = 0;
    int          sb_tail = 0;
    int          seq = 0;
    int          max_ret = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic read_arf(input logic [3:0] r, output logic [31:0] v);
        arf_raddr = r;
        #1;
        v = arf_rdata;
    endtask

    // Driver: allocate n lanes and queue the ones expected to retire.
    task automatic do_alloc(input int n, input logic [2:0] wr, input logic [2:0] br,
                            input logic [2:0] st, input logic [2:0] keep,
                            input logic [11:0] dsts);
        exp_t e;
        check("R3", "alloc_ready before allocation", 32'(alloc_ready), 32'd1);
        for (int l = 0; l < 3; l++) begin
            if (l < n) begin
                int t;
                t = (sb_tail + l) % DEPTH;
                check("R2", "allocated tag", 32'(alloc_tag[l*6 +: 6]), 32'(t));
                pc_of[t]  = 32'h0000_4000 + 32'(seq * 4);
                val_of[t] = 32'h5000_0000 + 32'(seq);
                seq++;
                alloc_valid[l]        = 1'b1;
                alloc_wr_en[l]        = wr[l];
                alloc_is_br[l]        = br[l];
                alloc_is_st[l]        = st[l];
                alloc_dst[l*4 +: 4]   = dsts[l*4 +: 4];
                alloc_pc[l*32 +: 32]  = pc_of[t];
                if (keep[l]) begin
                    e.wr  = wr[l];
                    e.dst = dsts[l*4 +: 4];
                    e.val = val_of[t];
                    e.st  = st[l];
                    exp_q.push_back(e);
                end
            end
        end
        tick();
        alloc_valid = '0;
        sb_tail = (sb_tail + n) % DEPTH;
    endtask

    task automatic do_wb(input int n, input logic [17:0] tags,
                         input logic [2:0] flt, input logic [2:0] mis);
        for (int l = 0; l < n; l++) begin
            wb_valid[l]          = 1'b1;
            wb_tag[l*6 +: 6]     = tags[l*6 +: 6];
            wb_fault[l]          = flt[l];
            wb_mispred[l]        = mis[l];
            wb_val[l*32 +: 32]   = val_of[tags[l*6 +: 6]];
        end
        tick();
        wb_valid = '0;
        wb_fault = '0;
        wb_mispred = '0;
    endtask

    // Monitor: pop expected items as lanes retire, oldest lane first.
    always @(negedge clk) begin
        if (!rst) begin
            int n;
            exp_t e;
            n = 0;
            for (int l = 0; l < 3; l++) begin
                if (ret_valid[l]) begin
                    n++;
                    if (exp_q.size() == 0) begin
                        check("R5", "unexpected retirement dst", 32'(ret_dst[l*4 +: 4]), 32'hFFFF_FFFF);
                    end else begin
                        e = exp_q.pop_front();
                        check("R5", "retired value in order", ret_val[l*32 +: 32], e.val);
                        check("R6", "retired write enable", 32'(ret_wr_en[l]), 32'(e.wr));
                        if (e.wr) check("R6", "retired destination", 32'(ret_dst[l*4 +: 4]), 32'(e.dst));
                        check("R7", "store release flag", 32'(ret_store[l]), 32'(e.st));
                    end
                end
            end
            if (n > max_ret) max_ret = n;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset state
        check("R1", "alloc_ready after reset", 32'(alloc_ready), 32'd1);
        check("R1", "ret_valid after reset", 32'(ret_valid), 32'd0);
        check("R1", "redirect/fault after reset", 32'({redirect_valid, fault_valid}), 32'd0);
        read_arf(4'd3, v);
        check("R1", "register 3 after reset", v, 32'd0);

        // R2, R4, R5, R6: out-of-order completion, in-order commit
        do_alloc(3, 3'b111, 3'b000, 3'b000, 3'b111, {4'd3, 4'd2, 4'd1});
        do_wb(1, 18'd2, 3'b000, 3'b000);
        check("R5", "no retire while head unfinished", 32'(ret_valid), 32'd0);
        do_wb(1, 18'd0, 3'b000, 3'b000);
        check("R5", "stop at first unfinished entry", 32'(ret_valid), 32'b001);
        read_arf(4'd1, v);
        check("R6", "register 1 before commit edge", v, 32'd0);
        do_wb(1, 18'd1, 3'b000, 3'b000);
        check("R4", "later lanes retire after completion", 32'(ret_valid), 32'b011);
        read_arf(4'd1, v);
        check("R6", "register 1 after commit", v, val_of[0]);
        read_arf(4'd2, v);
        check("R6", "register 2 not yet committed", v, 32'd0);
        tick();
        read_arf(4'd3, v);
        check("R6", "register 3 after commit", v, val_of[2]);

        // R3, R10: fill to 39 across the wrap, refused allocation, full drain
        for (int g = 0; g < 13; g++) begin
            do_alloc(3, 3'b111, 3'b000, 3'b000, 3'b111, {4'd12, 4'd11, 4'd10});
        end
        check("R3", "alloc_ready with one free slot", 32'(alloc_ready), 32'd0);
        alloc_valid = 3'b111;
        alloc_dst   = {4'd14, 4'd14, 4'd14};
        tick();
        alloc_valid = '0;
        for (int g = 0; g < 13; g++) begin
            int b;
            b = 3 + 3 * g;
            do_wb(3, {6'((b + 2) % DEPTH), 6'((b + 1) % DEPTH), 6'(b % DEPTH)},
                  3'b000, 3'b000);
        end
        repeat (3) tick();
        check("R5", "maximum retire width", 32'(max_ret), 32'd3);
        check("R10", "queue drained across wrap", 32'(exp_q.size()), 32'd0);

        // R8, R11: mispredicted branch keeps older, drops younger
        do_alloc(3, 3'b101, 3'b010, 3'b000, 3'b011, {4'd6, 4'd0, 4'd5});
        do_alloc(3, 3'b111, 3'b000, 3'b000, 3'b000, {4'd7, 4'd8, 4'd9});
        do_wb(3, {6'd7, 6'd6, 6'd4}, 3'b000, 3'b000);
        do_wb(1, 18'd3, 3'b000, 3'b001);
        check("R8", "no redirect before branch is oldest", 32'(redirect_valid), 32'd0);
        do_wb(1, 18'd2, 3'b000, 3'b000);
        check("R8", "branch and older retire", 32'(ret_valid), 32'b011);
        check("R8", "redirect raised", 32'(redirect_valid), 32'd1);
        check("R8", "redirect target", redirect_pc, val_of[3]);
        check("R11", "allocation blocked in flush cycle", 32'(alloc_ready), 32'd0);
        tick();
        read_arf(4'd5, v);
        check("R8", "older entry committed", v, val_of[2]);
        read_arf(4'd6, v);
        check("R8", "younger entry discarded", v, 32'd0);
        sb_tail = 4;

        // R9: fault reported only at the head
        do_alloc(3, 3'b111, 3'b000, 3'b000, 3'b001, {4'd9, 4'd8, 4'd7});
        do_wb(1, 18'd6, 3'b000, 3'b000);
        do_wb(1, 18'd5, 3'b001, 3'b000);
        check("R9", "fault waits for older work", 32'(fault_valid), 32'd0);
        do_wb(1, 18'd4, 3'b000, 3'b000);
        check("R9", "fault raised at head", 32'(fault_valid), 32'd1);
        check("R9", "fault address", fault_pc, pc_of[5]);
        check("R9", "only older lane retires", 32'(ret_valid), 32'b001);
        check("R11", "allocation blocked in fault cycle", 32'(alloc_ready), 32'd0);
        tick();
        read_arf(4'd8, v);
        check("R9", "faulting entry wrote nothing", v, 32'd0);
        read_arf(4'd9, v);
        check("R9", "younger than fault discarded", v, 32'd0);
        read_arf(4'd7, v);
        check("R9", "older than fault committed", v, val_of[4]);
        sb_tail = 5;

        // R7: store released only at retirement
        do_alloc(2, 3'b001, 3'b000, 3'b010, 3'b011, {4'd0, 4'd0, 4'd13});
        do_wb(1, 18'd6, 3'b000, 3'b000);
        check("R7", "store held behind older work", 32'(ret_store), 32'd0);
        do_wb(1, 18'd5, 3'b000, 3'b000);
        check("R7", "store released at retire", 32'(ret_store), 32'b010);
        repeat (2) tick();
        check("R5", "scoreboard empty at end", 32'(exp_q.size()), 32'd0);

        finish_run();
    end

endmodule